// File: doc/BRIEF.md
# Indexed Byte-Port Bus Bridge

This block is one logical device in an indexed configuration space. It lets a host that can only move single bytes reach a 32-bit internal bus. The host stages a bus address and a data word one byte at a time through indexed byte registers, most significant byte at the lowest index. It then starts exactly one bus access. A write access starts when a magic byte is written to the trigger register. A read access starts as a side effect of reading that register. When the read data comes back, it lands in the data staging registers, and the host collects it byte by byte.

Requests go to the internal bus through a valid/ready handshake. Read data returns on a separate valid strobe. A size register selects a 1-, 2- or 4-byte access on the low byte lanes. A busy flag covers the whole transaction, and while it is set all configuration writes and further triggers are refused.

Top module: `ibb_top`

## Requirements
- R1: After a synchronous active-low reset: the enable register is 0x00; the address and data staging are 0; the size register is 0x02; bus_req_valid is 0; busy is 0.
- R2: When cfg_ldev equals 0x0D, index 0x30 is the enable byte. Indices 0xF0..0xF3 hold address bits [31:24],[23:16],[15:8],[7:0]. Indices 0xF4..0xF7 hold data bits [31:24] down to [7:0]. Index 0xF8 is the size byte. Each of these reads back on cfg_rdata in the same cycle. bus_addr always shows the staged address.
- R3: A write of 0xCF to index 0xFE, made while enabled and idle, raises bus_req_valid with bus_req_write=1 in the next cycle. The request carries the staged address and data.
- R4: A write of any value other than 0xCF to index 0xFE starts no request.
- R5: A read of index 0xFE, made while enabled and idle, raises bus_req_valid with bus_req_write=0 in the next cycle. That read returns 0x00.
- R6: While bus_req_valid is high and bus_req_ready is low, the request stays asserted and keeps its address, data, direction and size unchanged.
- R7: After a read request is accepted, the first bus_rsp_valid stores bus_rdata, masked to the access size, into the data staging. The data then reads back at 0xF4..0xF7.
- R8: When the enable byte is not exactly 0x01, neither trigger starts a request.
- R9: busy is high from the cycle after a trigger until a write handshake completes or the read response arrives. While busy, all configuration writes and triggers are ignored.
- R10: bus_size equals size[1:0]. Code 0 is a 1-byte access and code 1 is a 2-byte access; any other code is a 4-byte access. bus_wdata and captured read data have the unused upper lanes forced to zero.
- R11: Configuration writes and reads with cfg_ldev not equal to 0x0D have no effect, and cfg_rdata is then 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_ldev | input | 8 | Currently selected logical device number |
| cfg_idx | input | 8 | Register index within the device |
| cfg_wr_en | input | 1 | Byte write strobe |
| cfg_wdata | input | 8 | Byte write data |
| cfg_rd_en | input | 1 | Byte read strobe |
| cfg_rdata | output | 8 | Byte read data for cfg_idx |
| bus_req_valid | output | 1 | Bus request valid |
| bus_req_ready | input | 1 | Bus request accepted |
| bus_req_write | output | 1 | 1 for write, 0 for read |
| bus_addr | output | 32 | Bus address |
| bus_wdata | output | 32 | Bus write data, lane-masked |
| bus_size | output | 2 | Access size code |
| bus_rsp_valid | input | 1 | Read data valid |
| bus_rdata | input | 32 | Read data |
| busy | output | 1 | Transaction in flight |

## Verification
The bench stages distinct byte patterns such as 0x12345678 and 0xAABBCCDD. With these it can tell a byte placed in the wrong lane or order from a correct one, because each byte is unique. Write triggers are tried with the bus ready held low for several cycles and then released. Read triggers get an immediate accept and a later response. The two cases separate a request that is held correctly from one that drops or changes early. Near-miss stimuli are each expected to leave the bus idle: the trigger byte 0x55, the enable value 0x03, a foreign device number, and writes made while busy. Sizes 0 and 1 with full-width read data show whether lane masking is done on both the write and the capture paths.

// File: rtl/ibb_pkg.sv
// Shared types and register index constants for the indexed byte-port bridge.
// Assumes byte-wide configuration access with 8-bit indices.
package ibb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } ibb_state_e;

    localparam logic [7:0] IDX_ENABLE   = 8'h30;
    localparam logic [7:0] IDX_STAGE0   = 8'hF0;
    localparam logic [7:0] IDX_TRIGGER  = 8'hFE;
    localparam logic [7:0] TRIG_MAGIC   = 8'hCF;
    localparam logic [7:0] ENABLE_ON    = 8'h01;
    localparam logic [7:0] SIZE_RESET   = 8'h02;
    localparam logic [1:0] SZ_BYTE      = 2'd0;
    localparam logic [1:0] SZ_HALF      = 2'd1;
endpackage

// File: rtl/ibb_stage_regs.sv
// Staging register file: enable byte, address bytes, data bytes, size byte.
// Address and data bytes are laid out MSB first from IDX_STAGE0 upward.
// Assumes wr_en is already qualified by device match and idle state.
module ibb_stage_regs
    import ibb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_sel,
    input  logic [7:0]        idx,
    input  logic [7:0]        wdata,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] cap_data,
    output logic [7:0]        enable_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic [1:0]        size_code,
    output logic [7:0]        rdata
);
    localparam int NA = ADDR_W / 8;
    localparam int NB = DATA_W / 8;
    localparam logic [7:0] IDX_DATA0 = IDX_STAGE0 + 8'(NA);
    localparam logic [7:0] IDX_SIZE  = IDX_STAGE0 + 8'(NA + NB);

    logic [7:0] size_q;

    // Enable and size byte registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable_q <= '0;
            size_q   <= SIZE_RESET;
        end else if (wr_en) begin
            if (idx == IDX_ENABLE) enable_q <= wdata;
            if (idx == IDX_SIZE)   size_q   <= wdata;
        end
    end

    genvar g;
    generate
        for (g = 0; g < NA; g++) begin : g_addr
            // One address byte; byte 0 is the most significant.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    addr_q[ADDR_W-1-8*g -: 8] <= '0;
                else if (wr_en && idx == IDX_STAGE0 + 8'(g))
                    addr_q[ADDR_W-1-8*g -: 8] <= wdata;
            end
        end
        for (g = 0; g < NB; g++) begin : g_data
            // One data byte; bus capture takes priority over host writes.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    data_q[DATA_W-1-8*g -: 8] <= '0;
                else if (cap_en)
                    data_q[DATA_W-1-8*g -: 8] <= cap_data[DATA_W-1-8*g -: 8];
                else if (wr_en && idx == IDX_DATA0 + 8'(g))
                    data_q[DATA_W-1-8*g -: 8] <= wdata;
            end
        end
    endgenerate

    assign size_code = size_q[1:0];

    // Readback multiplexer for the selected index.
    always_comb begin
        rdata = '0;
        if (rd_sel) begin
            if (idx == IDX_ENABLE) rdata = enable_q;
            if (idx == IDX_SIZE)   rdata = size_q;
            for (int i = 0; i < NA; i++)
                if (idx == IDX_STAGE0 + 8'(i)) rdata = addr_q[ADDR_W-1-8*i -: 8];
            for (int i = 0; i < NB; i++)
                if (idx == IDX_DATA0 + 8'(i)) rdata = data_q[DATA_W-1-8*i -: 8];
        end
    end

    // R7: a capture must land the returned (already masked) word.
    assert_capture_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> data_q == $past(cap_data));
endmodule

// File: rtl/ibb_trigger.sv
// Trigger decode: turns a magic write or a read of the trigger index
// into a one-cycle start pulse. Assumes hits are already device-qualified.
module ibb_trigger
    import ibb_pkg::*;
(
    input  logic       hit_wr,
    input  logic       hit_rd,
    input  logic [7:0] idx,
    input  logic [7:0] wdata,
    input  logic [7:0] enable_q,
    input  logic       busy,
    output logic       start,
    output logic       start_write
);
    logic armed;
    logic wr_go;
    logic rd_go;

    // Qualify both trigger kinds by enable value and idle state.
    always_comb begin
        armed       = (enable_q == ENABLE_ON) && !busy && (idx == IDX_TRIGGER);
        wr_go       = armed && hit_wr && (wdata == TRIG_MAGIC);
        rd_go       = armed && hit_rd && !hit_wr;
        start       = wr_go || rd_go;
        start_write = wr_go;
    end
endmodule

// File: rtl/ibb_bus_seq.sv
// Bus sequencer: issues one request per start pulse, holds it until ready,
// waits for read data and hands it back lane-masked for capture.
// Assumes a single outstanding transaction and in-order read return.
module ibb_bus_seq
    import ibb_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_write,
    input  logic [1:0]        size_code,
    input  logic [DATA_W-1:0] data_q,
    input  logic              req_ready,
    input  logic              rsp_valid,
    input  logic [DATA_W-1:0] rsp_data,
    output logic              req_valid,
    output logic              req_write,
    output logic [DATA_W-1:0] req_wdata,
    output logic              cap_en,
    output logic [DATA_W-1:0] cap_data,
    output logic              busy
);
    ibb_state_e state_q;
    logic [DATA_W-1:0] lane_mask;

    // Lane mask from the size code; low lanes only for narrow sizes.
    always_comb begin
        unique case (size_code)
            SZ_BYTE: lane_mask = {{(DATA_W-8){1'b0}}, 8'hFF};
            SZ_HALF: lane_mask = {{(DATA_W-16){1'b0}}, 16'hFFFF};
            default: lane_mask = '1;
        endcase
    end

    // Transaction state and direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            req_write <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start) begin
                    state_q   <= ST_REQ;
                    req_write <= start_write;
                end
                ST_REQ: if (req_ready)
                    state_q <= req_write ? ST_IDLE : ST_WAIT;
                ST_WAIT: if (rsp_valid)
                    state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Output decode of the sequencer state.
    always_comb begin
        req_valid = (state_q == ST_REQ);
        busy      = (state_q != ST_IDLE);
        req_wdata = data_q & lane_mask;
        cap_en    = (state_q == ST_WAIT) && rsp_valid;
        cap_data  = rsp_data & lane_mask;
    end

    // R6: an unaccepted request stays put with its contents.
    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_write)
        && $stable(req_wdata) && $stable(size_code));
    // R9: an accepted write ends the transaction.
    assert_write_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && req_write |=> !busy);
    // R5: an accepted read drops the request and stays busy.
    assert_read_wait_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !req_write |=> busy && !req_valid);
endmodule

// File: rtl/ibb_top.sv
// Indexed byte-port bus bridge: a logical device that stages a bus address
// and data byte-wise and runs one bus access per trigger.
// Assumes the index/unlock front end presents one byte access per strobe.
module ibb_top
    import ibb_pkg::*;
#(
    parameter int         ADDR_W  = 32,
    parameter int         DATA_W  = 32,
    parameter logic [7:0] DEV_SEL = 8'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_ldev,
    input  logic [7:0]        cfg_idx,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wdata,
    input  logic              cfg_rd_en,
    output logic [7:0]        cfg_rdata,
    output logic              bus_req_valid,
    input  logic              bus_req_ready,
    output logic              bus_req_write,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [1:0]        bus_size,
    input  logic              bus_rsp_valid,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              busy
);
    logic              dev_hit;
    logic              hit_wr;
    logic              hit_rd;
    logic              stage_wr;
    logic [7:0]        enable_q;
    logic [DATA_W-1:0] data_q;
    logic              start;
    logic              start_write;
    logic              cap_en;
    logic [DATA_W-1:0] cap_data;

    // Device match and write qualification.
    always_comb begin
        dev_hit  = (cfg_ldev == DEV_SEL);
        hit_wr   = cfg_wr_en && dev_hit;
        hit_rd   = cfg_rd_en && dev_hit;
        stage_wr = hit_wr && !busy;
    end

    ibb_stage_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (stage_wr),
        .rd_sel   (dev_hit),
        .idx      (cfg_idx),
        .wdata    (cfg_wdata),
        .cap_en   (cap_en),
        .cap_data (cap_data),
        .enable_q (enable_q),
        .addr_q   (bus_addr),
        .data_q   (data_q),
        .size_code(bus_size),
        .rdata    (cfg_rdata)
    );

    ibb_trigger u_trig (
        .hit_wr     (hit_wr),
        .hit_rd     (hit_rd),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .enable_q   (enable_q),
        .busy       (busy),
        .start      (start),
        .start_write(start_write)
    );

    ibb_bus_seq #(.DATA_W(DATA_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_write(start_write),
        .size_code  (bus_size),
        .data_q     (data_q),
        .req_ready  (bus_req_ready),
        .rsp_valid  (bus_rsp_valid),
        .rsp_data   (bus_rdata),
        .req_valid  (bus_req_valid),
        .req_write  (bus_req_write),
        .req_wdata  (bus_wdata),
        .cap_en     (cap_en),
        .cap_data   (cap_data),
        .busy       (busy)
    );

    // R8: with the enable byte not 0x01, an idle bridge stays idle.
    assert_disabled_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && enable_q != ENABLE_ON |=> !bus_req_valid);
    // R4: a non-magic trigger write with no read starts nothing.
    assert_bad_magic_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && hit_wr && cfg_idx == IDX_TRIGGER && cfg_wdata != TRIG_MAGIC
        |=> !bus_req_valid);
    // R10: a byte-sized request drives zero on the upper lanes.
    assert_lane_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && bus_size == SZ_BYTE |-> bus_wdata[DATA_W-1:8] == '0);
    // R9: a start only ever comes from the idle state.
    assert_no_retrigger_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start);
endmodule

// File: tb/sim_ibb_top.sv
// Bench for ibb_top: behavioural reference model compared on every clock,
// plus directed checks derived from the requirements.
module sim_ibb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_ldev = 8'h0D;
    logic [7:0]  cfg_idx = '0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic        cfg_rd_en = 1'b0;
    logic [7:0]  cfg_rdata;
    logic        bus_req_valid;
    logic        bus_req_ready = 1'b0;
    logic        bus_req_write;
    logic [31:0] bus_addr;
    logic [31:0] bus_wdata;
    logic [1:0]  bus_size;
    logic        bus_rsp_valid = 1'b0;
    logic [31:0] bus_rdata = '0;
    logic        busy;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    ibb_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_ldev(cfg_ldev), .cfg_idx(cfg_idx),
        .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata), .cfg_rd_en(cfg_rd_en),
        .cfg_rdata(cfg_rdata), .bus_req_valid(bus_req_valid),
        .bus_req_ready(bus_req_ready), .bus_req_write(bus_req_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_size(bus_size),
        .bus_rsp_valid(bus_rsp_valid), .bus_rdata(bus_rdata), .busy(busy)
    );

    // Reference model state: 0 idle, 1 requesting, 2 waiting for data.
    logic [7:0]  m_en = 8'h00;
    logic [31:0] m_addr = '0;
    logic [31:0] m_data = '0;
    logic [7:0]  m_size = 8'h02;
    int          m_st = 0;
    bit          m_wr = 1'b0;

    function automatic logic [31:0] lane(input logic [7:0] sz);
        if (sz[1:0] == 2'd0) return 32'h0000_00FF;
        if (sz[1:0] == 2'd1) return 32'h0000_FFFF;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic logic [7:0] m_rd(input logic [7:0] dev, input logic [7:0] ix);
        if (dev != 8'h0D) return 8'h00;
        case (ix)
            8'h30: return m_en;
            8'hF0: return m_addr[31:24];
            8'hF1: return m_addr[23:16];
            8'hF2: return m_addr[15:8];
            8'hF3: return m_addr[7:0];
            8'hF4: return m_data[31:24];
            8'hF5: return m_data[23:16];
            8'hF6: return m_data[15:8];
            8'hF7: return m_data[7:0];
            8'hF8: return m_size;
            default: return 8'h00;
        endcase
    endfunction

    // Advance the model on each rising edge from the applied inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_en = 8'h00; m_addr = '0; m_data = '0; m_size = 8'h02; m_st = 0; m_wr = 1'b0;
        end else begin
            case (m_st)
                0: begin
                    bit hw, hr;
                    hw = cfg_wr_en && cfg_ldev == 8'h0D;
                    hr = cfg_rd_en && cfg_ldev == 8'h0D;
                    if (hw && cfg_idx == 8'hFE && cfg_wdata == 8'hCF && m_en == 8'h01) begin
                        m_st = 1; m_wr = 1'b1;
                    end else if (hr && !hw && cfg_idx == 8'hFE && m_en == 8'h01) begin
                        m_st = 1; m_wr = 1'b0;
                    end
                    if (hw) begin
                        case (cfg_idx)
                            8'h30: m_en = cfg_wdata;
                            8'hF0: m_addr[31:24] = cfg_wdata;
                            8'hF1: m_addr[23:16] = cfg_wdata;
                            8'hF2: m_addr[15:8]  = cfg_wdata;
                            8'hF3: m_addr[7:0]   = cfg_wdata;
                            8'hF4: m_data[31:24] = cfg_wdata;
                            8'hF5: m_data[23:16] = cfg_wdata;
                            8'hF6: m_data[15:8]  = cfg_wdata;
                            8'hF7: m_data[7:0]   = cfg_wdata;
                            8'hF8: m_size = cfg_wdata;
                            default: ;
                        endcase
                    end
                end
                1: if (bus_req_ready) m_st = m_wr ? 0 : 2;
                default: if (bus_rsp_valid) begin
                    m_data = bus_rdata & lane(m_size);
                    m_st = 0;
                end
            endcase
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare the design against the model on every falling edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R3/R5 valid", {31'b0, bus_req_valid}, {31'b0, m_st == 1});
            chk("R9 busy", {31'b0, busy}, {31'b0, m_st != 0});
            if (m_st != 0) chk("R3/R5 dir", {31'b0, bus_req_write}, {31'b0, m_wr});
            chk("R2 addr", bus_addr, m_addr);
            chk("R10 wdata", bus_wdata, m_data & lane(m_size));
            chk("R10 size", {30'b0, bus_size}, {30'b0, m_size[1:0]});
            chk("R2 rdata", {24'b0, cfg_rdata}, {24'b0, m_rd(cfg_ldev, cfg_idx)});
        end
    end

    task automatic cyc();
        @(negedge clk); #2;
    endtask

    task automatic wr(input logic [7:0] ix, input logic [7:0] v);
        cfg_idx = ix; cfg_wdata = v; cfg_wr_en = 1'b1;
        cyc();
        cfg_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] ix, output logic [7:0] v);
        cfg_idx = ix; cfg_rd_en = 1'b1;
        #1 v = cfg_rdata;
        cyc();
        cfg_rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (3) cyc();
        // R1: reset state
        chk("R1 valid", {31'b0, bus_req_valid}, 32'd0);
        chk("R1 busy", {31'b0, busy}, 32'd0);
        chk("R1 addr", bus_addr, 32'd0);
        chk("R1 size", {30'b0, bus_size}, 32'd2);
        rst_n = 1'b1;
        cyc();
        rd(8'h30, b); chk("R1 enable", {24'b0, b}, 32'h00);
        rd(8'hF8, b); chk("R1 size byte", {24'b0, b}, 32'h02);

        // R2: staging, MSB first
        wr(8'h30, 8'h01);
        wr(8'hF0, 8'h12); wr(8'hF1, 8'h34); wr(8'hF2, 8'h56); wr(8'hF3, 8'h78);
        wr(8'hF4, 8'hAA); wr(8'hF5, 8'hBB); wr(8'hF6, 8'hCC); wr(8'hF7, 8'hDD);
        chk("R2 addr", bus_addr, 32'h1234_5678);
        chk("R2 data", bus_wdata, 32'hAABB_CCDD);
        rd(8'hF4, b); chk("R2 F4", {24'b0, b}, 32'hAA);
        rd(8'hF3, b); chk("R2 F3", {24'b0, b}, 32'h78);

        // R11: foreign device ignored
        cfg_ldev = 8'h07;
        wr(8'hF0, 8'hFF);
        rd(8'hF1, b); chk("R11 rdata", {24'b0, b}, 32'h00);
        rd(8'hFE, b);
        chk("R11 no req", {31'b0, bus_req_valid}, 32'd0);
        cfg_ldev = 8'h0D;
        chk("R11 addr", bus_addr, 32'h1234_5678);

        // R4: wrong magic
        wr(8'hFE, 8'h55);
        chk("R4 no req", {31'b0, bus_req_valid}, 32'd0);

        // R3, R6, R9: write held without ready
        wr(8'hFE, 8'hCF);
        chk("R3 valid", {31'b0, bus_req_valid}, 32'd1);
        chk("R3 write", {31'b0, bus_req_write}, 32'd1);
        cyc(); cyc();
        chk("R6 held", {31'b0, bus_req_valid}, 32'd1);
        chk("R6 addr", bus_addr, 32'h1234_5678);
        wr(8'hF0, 8'h99);
        chk("R9 addr ignored", bus_addr, 32'h1234_5678);
        bus_req_ready = 1'b1;
        cyc();
        chk("R9 done", {31'b0, busy}, 32'd0);

        // R5, R7: read with immediate accept, later response
        rd(8'hFE, b);
        chk("R5 rd value", {24'b0, b}, 32'h00);
        chk("R5 valid", {31'b0, bus_req_valid}, 32'd1);
        chk("R5 dir", {31'b0, bus_req_write}, 32'd0);
        cyc();
        bus_req_ready = 1'b0;
        chk("R5 wait", {31'b0, busy}, 32'd1);
        rd(8'hFE, b);
        chk("R9 no retrigger", {31'b0, bus_req_valid}, 32'd0);
        bus_rdata = 32'hCAFE_F00D; bus_rsp_valid = 1'b1;
        cyc();
        bus_rsp_valid = 1'b0;
        chk("R7 idle", {31'b0, busy}, 32'd0);
        rd(8'hF4, b); chk("R7 F4", {24'b0, b}, 32'hCA);
        rd(8'hF7, b); chk("R7 F7", {24'b0, b}, 32'h0D);

        // R10: byte and half sizes
        wr(8'hF8, 8'h00);
        chk("R10 byte wdata", bus_wdata, 32'h0000_000D);
        bus_req_ready = 1'b1;
        rd(8'hFE, b);
        cyc();
        bus_req_ready = 1'b0;
        bus_rdata = 32'h1122_3344; bus_rsp_valid = 1'b1;
        cyc();
        bus_rsp_valid = 1'b0;
        rd(8'hF6, b); chk("R10 upper zero", {24'b0, b}, 32'h00);
        rd(8'hF7, b); chk("R10 low byte", {24'b0, b}, 32'h44);
        wr(8'hF4, 8'h77); wr(8'hF6, 8'h66); wr(8'hF8, 8'h01);
        chk("R10 half wdata", bus_wdata, 32'h0000_6644);

        // R8: enable not 0x01
        wr(8'h30, 8'h03);
        wr(8'hFE, 8'hCF);
        chk("R8 no write req", {31'b0, bus_req_valid}, 32'd0);
        rd(8'hFE, b);
        chk("R8 no read req", {31'b0, bus_req_valid}, 32'd0);
        cyc();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule